// File: doc/BRIEF.md
# Field-Synchronized Shadow Base Registers

This block is a small register bank inside a video capture engine. It holds two graphics-memory base addresses, one for the even field and one for the odd field. The capture datapath stores vertical-blanking data starting at these addresses. Software programs the addresses through a single-cycle memory-mapped port. A write never reaches the capture logic at once. It lands in a pending shadow copy, and the capture logic keeps working from its active copy.

The capture logic raises a one-cycle pulse on `field_first_data` when it captures the first data of a new field. If any write is outstanding at that moment, every pending value is copied into its active register in that same cycle, with the low five address bits forced to zero. The outstanding-update flag then clears. A two-state controller tracks the flag. `ST_CLEAN` means active and pending agree. `ST_DIRTY` means a write is waiting.

The controller has these transitions:
- T_WRITE: any base write, CLEAN→DIRTY.
- T_REWRITE: any base write, DIRTY→DIRTY.
- T_COMMIT: a field pulse with no base write, DIRTY→CLEAN.
- T_HOLD: neither event, state kept.

A field pulse in `ST_CLEAN` is a T_HOLD.

Top module: `field_base_shadow`

## Requirements
- R1: After reset, both active outputs, both base read values and the status register all read as 0x00000000.
- R2: A write to offset 0x20 (even base) or 0x24 (odd base) stores the full 32-bit value in the pending copy. A read of that offset from the next cycle on returns it, including bits [4:0].
- R3: A base write leaves both active outputs unchanged until a commit takes place.
- R4: A write to either base offset makes bit 16 of the status register at offset 0x08 read as 1 from the next cycle. All other status bits read as 0.
- R5: A field pulse while the flag is set commits as follows. From the next cycle, each active output equals its pending value with bits [4:0] cleared, and the flag reads 0.
- R6: A field pulse while the flag is clear leaves both active outputs unchanged.
- R7: A field pulse and a base write in the same cycle are handled together. The commit uses the pending values held before that write. The new value stays pending, and the flag stays 1.
- R8: Writes to offset 0x08 and to unmapped offsets change nothing. Reads of unmapped offsets return 0.
- R9: `reg_rdata` is 0 in any cycle without a read (`reg_valid` low or `reg_write` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access in this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, same cycle |
| field_first_data | input | 1 | One-cycle pulse: first data of a new field captured |
| even_base_active | output | 32 | Active even-field base for the capture datapath |
| odd_base_active | output | 32 | Active odd-field base for the capture datapath |

## Verification
The assertions assume that `field_first_data` is a level sampled each cycle, not necessarily a single pulse. They hold even if it stays high for several cycles. The assertions also assume that register accesses carry no handshake, so every valid cycle completes. The stimulus drives inputs only at the falling edge, so each access and pulse is seen at exactly one rising edge. It places field pulses in both the clean and the dirty state and deliberately overlaps writes with pulses. A random phase mixes mapped, status and unmapped offsets with unaligned data, so the low-bit clearing is exercised.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    // Commit controller states
    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_DIRTY = 1'b1
    } fbs_state_e;

    // Number of shadowed base registers (even, odd)
    localparam int FBS_NUM_BASE = 2;

endpackage

// File: rtl/fbs_addr_decode.sv
module fbs_addr_decode #(
    parameter int ADDR_W      = 8,
    parameter int NUM_BASE    = 2,
    parameter int BASE_OFS    = 'h20,
    parameter int BASE_STRIDE = 4,
    parameter int STAT_OFS    = 'h08
) (
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [ADDR_W-1:0]   reg_addr,
    output logic [NUM_BASE-1:0] base_wr,
    output logic [NUM_BASE-1:0] base_rd,
    output logic                stat_rd,
    output logic                any_base_wr,
    output logic                is_read
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

    logic rd_cycle;
    logic wr_cycle;

    assign rd_cycle = reg_valid && !reg_write;
    assign wr_cycle = reg_valid &&  reg_write;
    assign is_read  = rd_cycle;

    for (genvar gi = 0; gi < NUM_BASE; gi++) begin : g_slot_dec
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_OFS + gi * BASE_STRIDE);
        logic hit;
        assign hit         = (reg_addr == SLOT_ADDR);
        assign base_wr[gi] = wr_cycle && hit;
        assign base_rd[gi] = rd_cycle && hit;
    end

    // Status register is read-only: no write strobe is produced for it
    assign stat_rd     = rd_cycle && (reg_addr == STAT_ADDR);
    assign any_base_wr = |base_wr;

endmodule

// File: rtl/fbs_base_slot.sv
module fbs_base_slot #(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output logic [DATA_W-1:0] pending,
    output logic [DATA_W-1:0] active
);

    localparam int UPPER_W = DATA_W - ALIGN_BITS;

    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] act_q;

    // Commit samples the pre-write pending value; a concurrent write lands after it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr_en) begin
                pend_q <= wr_data;
            end
            if (commit) begin
                act_q <= {pend_q[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            end
        end
    end

    assign pending = pend_q;
    assign active  = act_q;

    AST_ACTIVE_STABLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_q)) else $error("active changed without commit"); // R3

    AST_ACTIVE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        act_q[ALIGN_BITS-1:0] == '0) else $error("active base not aligned"); // R5

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> act_q[DATA_W-1:ALIGN_BITS] == $past(pend_q[DATA_W-1:ALIGN_BITS]))
        else $error("commit did not copy pending"); // R5

    logic [UPPER_W-1:0] unused_chk;
    assign unused_chk = '0;

endmodule

// File: rtl/fbs_commit_fsm.sv
module fbs_commit_fsm
    import fbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_base_wr,
    input  logic field_first,
    output logic commit,
    output logic dirty
);

    fbs_state_e state_q;
    fbs_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a write always wins over a commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (any_base_wr) state_d = ST_DIRTY;          // T_WRITE
            end
            ST_DIRTY: begin
                if (any_base_wr)      state_d = ST_DIRTY;     // T_REWRITE
                else if (field_first) state_d = ST_CLEAN;     // T_COMMIT
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // Outputs
    always_comb begin
        commit = 1'b0;
        dirty  = 1'b0;
        unique case (state_q)
            ST_CLEAN: begin
                commit = 1'b0;
                dirty  = 1'b0;
            end
            ST_DIRTY: begin
                commit = field_first;
                dirty  = 1'b1;
            end
            default: begin
                commit = 1'b0;
                dirty  = 1'b0;
            end
        endcase
    end

    AST_FLAG_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        any_base_wr |=> dirty) else $error("flag not set after write"); // R4

    AST_COMMIT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty && field_first && !any_base_wr) |=> !dirty)
        else $error("flag not cleared by commit"); // R5

    AST_COLLISION_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (field_first && any_base_wr) |=> dirty)
        else $error("flag lost on collision"); // R7

endmodule

// File: rtl/field_base_shadow.sv
module field_base_shadow #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int BASE_OFS    = 'h20,
    parameter int BASE_STRIDE = 4,
    parameter int STAT_OFS    = 'h08,
    parameter int FLAG_BIT    = 16,
    parameter int ALIGN_BITS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              field_first_data,
    output logic [DATA_W-1:0] even_base_active,
    output logic [DATA_W-1:0] odd_base_active
);

    import fbs_pkg::*;

    localparam int NB      = FBS_NUM_BASE;
    localparam int SLOT_EV = 0;
    localparam int SLOT_OD = 1;

    logic [NB-1:0]     base_wr;
    logic [NB-1:0]     base_rd;
    logic              stat_rd;
    logic              any_base_wr;
    logic              is_read;
    logic              commit;
    logic              dirty;
    logic [DATA_W-1:0] pend [NB];
    logic [DATA_W-1:0] act  [NB];

    fbs_addr_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_BASE   (NB),
        .BASE_OFS   (BASE_OFS),
        .BASE_STRIDE(BASE_STRIDE),
        .STAT_OFS   (STAT_OFS)
    ) u_dec (
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .base_wr    (base_wr),
        .base_rd    (base_rd),
        .stat_rd    (stat_rd),
        .any_base_wr(any_base_wr),
        .is_read    (is_read)
    );

    fbs_commit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_base_wr(any_base_wr),
        .field_first(field_first_data),
        .commit     (commit),
        .dirty      (dirty)
    );

    for (genvar gs = 0; gs < NB; gs++) begin : g_slot
        fbs_base_slot #(
            .DATA_W    (DATA_W),
            .ALIGN_BITS(ALIGN_BITS)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (base_wr[gs]),
            .wr_data(reg_wdata),
            .commit (commit),
            .pending(pend[gs]),
            .active (act[gs])
        );
    end

    // Read mux: pending values, status flag, zero elsewhere
    always_comb begin
        reg_rdata = '0;
        if (stat_rd) begin
            reg_rdata[FLAG_BIT] = dirty;
        end
        for (int k = 0; k < NB; k++) begin
            if (base_rd[k]) reg_rdata = pend[k];
        end
    end

    assign even_base_active = act[SLOT_EV];
    assign odd_base_active  = act[SLOT_OD];

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |-> reg_rdata == '0) else $error("rdata not zero outside read"); // R9

    AST_CLEAN_PULSE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (field_first_data && !dirty) |=> ($stable(even_base_active) && $stable(odd_base_active)))
        else $error("active changed on clean pulse"); // R6

endmodule

// File: tb/field_base_shadow_bench.sv
`timescale 1ns/1ps
module field_base_shadow_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        field_first_data = 1'b0;
    logic [31:0] even_base_active;
    logic [31:0] odd_base_active;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    field_base_shadow u_field_base_shadow (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_valid       (reg_valid),
        .reg_write       (reg_write),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .field_first_data(field_first_data),
        .even_base_active(even_base_active),
        .odd_base_active (odd_base_active)
    );

    // Behavioural reference model
    logic [31:0] m_pend_ev = 0, m_pend_od = 0, m_act_ev = 0, m_act_od = 0;
    bit          m_dirty = 0;

    always @(posedge clk) begin
        bit wr_ev, wr_od, cm;
        if (!rst_n) begin
            m_pend_ev <= 0; m_pend_od <= 0; m_act_ev <= 0; m_act_od <= 0; m_dirty <= 0;
        end else begin
            wr_ev = reg_valid && reg_write && reg_addr == 8'h20;
            wr_od = reg_valid && reg_write && reg_addr == 8'h24;
            cm    = m_dirty && field_first_data;
            if (cm) begin
                m_act_ev <= m_pend_ev & 32'hFFFF_FFE0;
                m_act_od <= m_pend_od & 32'hFFFF_FFE0;
            end
            if (wr_ev) m_pend_ev <= reg_wdata;
            if (wr_od) m_pend_od <= reg_wdata;
            if (wr_ev || wr_od) m_dirty <= 1;
            else if (cm)        m_dirty <= 0;
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!rst_n || !reg_valid || reg_write) return 32'h0;
        case (reg_addr)
            8'h20:   return m_pend_ev;
            8'h24:   return m_pend_od;
            8'h08:   return {15'h0, m_dirty, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", cur_tag, what, act, exp);
        end
    endtask

    // Compare at the falling edge, then apply the next stimulus
    task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] d, bit f, string tag);
        @(negedge clk);
        chk("even_base_active", even_base_active, m_act_ev);
        chk("odd_base_active",  odd_base_active,  m_act_od);
        chk("reg_rdata",        reg_rdata,        exp_rdata());
        cur_tag = tag;
        reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d; field_first_data = f;
    endtask

    task automatic idle(string tag);
        step(0, 0, 8'h00, 32'h0, 0, tag);
    endtask

    task automatic rd(logic [7:0] a, string tag);
        step(1, 0, a, 32'h0, 0, tag);
    endtask

    initial begin
        // R1: reset state
        step(1, 0, 8'h20, 0, 0, "R1");
        step(1, 0, 8'h24, 0, 0, "R1");
        step(1, 0, 8'h08, 0, 0, "R1");
        rst_n = 1'b1;
        rd(8'h20, "R1"); rd(8'h24, "R1"); rd(8'h08, "R1");
        // R2 R3 R4: writes land pending only, flag sets
        step(1, 1, 8'h20, 32'h1234_567F, 0, "R2");
        rd(8'h20, "R2");
        rd(8'h08, "R4");
        step(1, 1, 8'h24, 32'hABCD_EF13, 0, "R3");
        rd(8'h24, "R2");
        idle("R3"); idle("R3");
        // R5: commit
        step(0, 0, 8'h00, 0, 1, "R5");
        rd(8'h08, "R5");
        // R6: pulse while clean
        step(0, 0, 8'h00, 0, 1, "R6");
        idle("R6");
        // R7: collision while dirty
        step(1, 1, 8'h20, 32'h0000_1F3F, 0, "R7");
        step(1, 1, 8'h24, 32'h5555_AAAA, 1, "R7");
        rd(8'h08, "R7"); rd(8'h24, "R7");
        step(0, 0, 8'h00, 0, 1, "R7");
        rd(8'h08, "R7");
        // R7 collision while clean: no commit
        step(1, 1, 8'h20, 32'hFFFF_FFFF, 1, "R7");
        rd(8'h08, "R7");
        step(0, 0, 8'h00, 0, 1, "R5");
        // R8: status and unmapped writes ignored
        step(1, 1, 8'h08, 32'hFFFF_FFFF, 0, "R8");
        rd(8'h08, "R8");
        step(1, 1, 8'h40, 32'hDEAD_BEEF, 0, "R8");
        step(1, 1, 8'h28, 32'hDEAD_BEEF, 0, "R8");
        rd(8'h40, "R8"); rd(8'h28, "R8"); rd(8'h08, "R8");
        rd(8'h20, "R8"); rd(8'h24, "R8");
        // R9: no read, rdata zero
        step(1, 1, 8'h20, 32'h0101_0101, 0, "R9");
        step(0, 0, 8'h20, 0, 0, "R9");
        idle("R9");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] addrs [6] = '{8'h08, 8'h20, 8'h24, 8'h28, 8'h40, 8'h00};
            step(1'($urandom), 1'($urandom), addrs[$urandom % 6], $urandom,
                 ($urandom % 4) == 0, "R7");
        end
        idle("R5"); idle("R5");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule